// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block is the control engine of one scatter-gather DMA channel. Software lays out a linked ring of descriptors in memory. Each descriptor holds a next pointer, a buffer address and a control word. The control word carries a transfer length and two packet-boundary flags, one marking the first piece of a packet and one marking the last. The walker reads each descriptor over a single-outstanding read port. It hands a transfer command to an external data mover and waits for the mover to report completion. It then stores a status word back into the descriptor and follows the next pointer. Because the ring's last entry points back to the first, the walk wraps with no extra logic.

Software starts and pauses the channel with run and stop pulses. While halted, it may load the current-descriptor register. A tail-pointer register marks where the walk ends: after finishing the descriptor whose address equals the tail, the channel stays running but idle. Moving the tail while idle resumes the walk from the next pointer of the last completed descriptor. Three faults stop the channel hard until a soft or hard reset: a misaligned descriptor address, an illegal length, and a mover fault.

Top module: `sg_chain_walker`

## Requirements
- R1: After rst_ni or a soft_rst_i pulse, the channel is halted (halted_o=1, idle_o=0) with err_code_o=0, and it issues no read, command or writeback until run_i is pulsed.
- R2: A descriptor at byte address D is fetched as three single reads at D+0 (next pointer), D+4 (buffer address) and D+8 (control). The mover command then carries that buffer address, the control length from bits [LEN_W-1:0], the first-piece flag from bit 31 and the last-piece flag from bit 30. At most one read is outstanding.
- R3: After the mover reports success, the walker writes to D+12 a status word with bit 31 set and the mover's reported length in bits [LEN_W-1:0]. This writeback completes before any further descriptor read.
- R4: After a descriptor that is not the tail completes, the next descriptor fetched is the one at that descriptor's next pointer, and a ring that points back to its start is walked again in order.
- R5: After completing the descriptor whose address equals the tail register, the channel stays running (halted_o=0), raises idle_o and issues no further reads.
- R6: Writing the tail register while idle restarts the walk at the next pointer of the last completed descriptor.
- R7: While halted, writes to the current-descriptor and tail registers are accepted, but no descriptor is read until run_i is pulsed.
- R8: A stop_i pulse during a walk lets the descriptor in flight finish, including its writeback, then halts. The current descriptor then points to the next one, and run_i resumes the walk from there.
- R9: A descriptor that does not carry both flags and whose length is not a multiple of WORD_BYTES raises err_code_o=2 and halts without issuing a mover command. A descriptor that carries both flags is exempt from this check.
- R10: Launching a fetch from an address whose low log2(ALIGN_BYTES) bits are not zero raises err_code_o=1, and no read is issued.
- R11: A mover completion with mov_err_i set raises err_code_o=3 and halts with no writeback.
- R12: While err_code_o is nonzero, the channel stays halted and ignores run_i and register writes; only a reset clears the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous channel reset; clears errors and halts |
| run_i | input | 1 | Start/resume pulse |
| stop_i | input | 1 | Pause pulse |
| cur_we_i | input | 1 | Write strobe for the current-descriptor register (halted only) |
| cur_wdata_i | input | AW | Current-descriptor write value |
| tail_we_i | input | 1 | Write strobe for the tail register |
| tail_wdata_i | input | AW | Tail write value |
| rd_req_o | output | 1 | Single-cycle read request |
| rd_addr_o | output | AW | Read byte address |
| rd_valid_i | input | 1 | Read response valid |
| rd_data_i | input | DW | Read response data |
| mov_valid_o | output | 1 | Transfer command valid |
| mov_ready_i | input | 1 | Mover accepts the command |
| mov_addr_o | output | AW | Buffer address |
| mov_len_o | output | LEN_W | Transfer length in bytes |
| mov_sof_o | output | 1 | First piece of a packet |
| mov_eof_o | output | 1 | Last piece of a packet |
| mov_done_i | input | 1 | Mover completion pulse |
| mov_err_i | input | 1 | Completion carries a fault |
| mov_xfer_len_i | input | LEN_W | Bytes actually moved |
| wb_valid_o | output | 1 | Status writeback valid |
| wb_ready_i | input | 1 | Writeback accepted |
| wb_addr_o | output | AW | Writeback byte address |
| wb_data_o | output | DW | Status word |
| halted_o | output | 1 | Channel halted (paused or faulted) |
| idle_o | output | 1 | Running and parked at the tail |
| err_code_o | output | 2 | 0 none, 1 misaligned, 2 bad length, 3 mover fault |
| cur_desc_o | output | AW | Current-descriptor register |

## Verification
The assertions assume that the read port returns exactly one response per request and never answers without one. They also assume that the mover raises mov_done_i only for a command it has accepted, and that control pulses arrive one at a time. The bench memory answers each request once, after a fixed latency. The bench mover completes only the command it took, a few cycles later. Every run, stop, register write and soft reset is a separate one-cycle pulse issued between clock edges, so the cases where the walker ignores an input are reached only by pulses the assumptions allow.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  typedef enum logic [2:0] {
    ST_HALT, ST_LAUNCH, ST_FETCH, ST_DISPATCH, ST_XFER, ST_WBACK, ST_IDLE, ST_ERROR
  } walk_state_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_ALIGN = 2'd1,
    ERR_LEN   = 2'd2,
    ERR_MOVER = 2'd3
  } walk_err_e;

  // descriptor word slots, in units of one descriptor word
  localparam int unsigned W_NEXT = 0;
  localparam int unsigned W_BUF  = 1;
  localparam int unsigned W_CTRL = 2;
  localparam int unsigned W_STAT = 3;
  localparam int unsigned DESC_FETCH_WORDS = 3;
endpackage

// File: rtl/sgw_fetch.sv
module sgw_fetch
  import sgw_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned NWORDS = DESC_FETCH_WORDS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [AW-1:0] base_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          done_o,
  output logic [AW-1:0] next_o,
  output logic [AW-1:0] buf_o,
  output logic [DW-1:0] ctrl_o
);
  localparam int unsigned IW     = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int unsigned STRIDE = DW / 8;

  typedef enum logic [1:0] {F_IDLE, F_ISSUE, F_WAIT} fetch_st_e;

  fetch_st_e     st_q;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] base_q;
  logic          done_q;
  logic [DW-1:0] words_q [NWORDS];
  logic          take;

  assign take = (st_q == F_WAIT) && rd_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= F_IDLE;
      idx_q  <= '0;
      base_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        st_q <= F_IDLE;
      end else begin
        unique case (st_q)
          F_IDLE: if (start_i) begin
            base_q <= base_i;
            idx_q  <= '0;
            st_q   <= F_ISSUE;
          end
          F_ISSUE: st_q <= F_WAIT;
          F_WAIT: if (rd_valid_i) begin
            if (idx_q == IW'(NWORDS - 1)) begin
              st_q   <= F_IDLE;
              done_q <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= F_ISSUE;
            end
          end
          default: st_q <= F_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NWORDS; i++) words_q[i] <= '0;
    end else begin
      for (int i = 0; i < NWORDS; i++)
        if (take && idx_q == IW'(i)) words_q[i] <= rd_data_i;
    end
  end

  assign rd_req_o  = (st_q == F_ISSUE);
  assign rd_addr_o = base_q + AW'(idx_q) * AW'(STRIDE);
  assign done_o    = done_q;
  assign next_o    = AW'(words_q[W_NEXT]);
  assign buf_o     = AW'(words_q[W_BUF]);
  assign ctrl_o    = words_q[W_CTRL];

  // R2
  single_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);

  // R2
  resp_only_waiting_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_req_o);
endmodule

// File: rtl/sgw_len_chk.sv
module sgw_len_chk #(
  parameter int unsigned DW         = 32,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic [DW-1:0]    ctrl_i,
  output logic             sof_o,
  output logic             eof_o,
  output logic [LEN_W-1:0] len_o,
  output logic             len_bad_o
);
  localparam int unsigned WB_LSB = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

  logic unused_ctrl;
  assign unused_ctrl = ^ctrl_i[DW-3:LEN_W];

  assign sof_o = ctrl_i[DW-1];
  assign eof_o = ctrl_i[DW-2];
  assign len_o = ctrl_i[LEN_W-1:0];

  // a descriptor holding a whole packet is exempt from the word-multiple rule
  generate
    if (WORD_BYTES > 1) begin : g_chk
      assign len_bad_o = !(sof_o && eof_o) && (len_o[WB_LSB-1:0] != '0);
    end else begin : g_nochk
      assign len_bad_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
  import sgw_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned DW          = 32,
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned WORD_BYTES  = 4,
  parameter int unsigned ALIGN_BYTES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             run_i,
  input  logic             stop_i,
  input  logic             cur_we_i,
  input  logic [AW-1:0]    cur_wdata_i,
  input  logic             tail_we_i,
  input  logic [AW-1:0]    tail_wdata_i,
  output logic             rd_req_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic             rd_valid_i,
  input  logic [DW-1:0]    rd_data_i,
  output logic             mov_valid_o,
  input  logic             mov_ready_i,
  output logic [AW-1:0]    mov_addr_o,
  output logic [LEN_W-1:0] mov_len_o,
  output logic             mov_sof_o,
  output logic             mov_eof_o,
  input  logic             mov_done_i,
  input  logic             mov_err_i,
  input  logic [LEN_W-1:0] mov_xfer_len_i,
  output logic             wb_valid_o,
  input  logic             wb_ready_i,
  output logic [AW-1:0]    wb_addr_o,
  output logic [DW-1:0]    wb_data_o,
  output logic             halted_o,
  output logic             idle_o,
  output logic [1:0]       err_code_o,
  output logic [AW-1:0]    cur_desc_o
);
  localparam int unsigned ALIGN_LSB = (ALIGN_BYTES > 1) ? $clog2(ALIGN_BYTES) : 1;
  localparam int unsigned STAT_OFS  = W_STAT * (DW / 8);

  walk_state_e      state_q;
  walk_err_e        err_q;
  logic [AW-1:0]    cur_q, tail_q;
  logic             at_tail_q, stop_pend_q;
  logic [LEN_W-1:0] act_len_q;

  logic             f_start, f_done;
  logic [AW-1:0]    f_next, f_buf;
  logic [DW-1:0]    f_ctrl;
  logic             d_sof, d_eof, d_len_bad;
  logic [LEN_W-1:0] d_len;
  logic             misaligned, stop_hit, at_tail_cmp;

  assign misaligned  = (ALIGN_BYTES > 1) && (cur_q[ALIGN_LSB-1:0] != '0);
  assign stop_hit    = stop_pend_q || stop_i;
  assign at_tail_cmp = (cur_q == tail_q);
  assign f_start     = (state_q == ST_LAUNCH) && !soft_rst_i && !stop_hit && !misaligned;

  sgw_fetch #(.AW(AW), .DW(DW), .NWORDS(DESC_FETCH_WORDS)) u_fetch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (f_start),
    .abort_i   (soft_rst_i),
    .base_i    (cur_q),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_valid_i(rd_valid_i),
    .rd_data_i (rd_data_i),
    .done_o    (f_done),
    .next_o    (f_next),
    .buf_o     (f_buf),
    .ctrl_o    (f_ctrl)
  );

  sgw_len_chk #(.DW(DW), .LEN_W(LEN_W), .WORD_BYTES(WORD_BYTES)) u_len (
    .ctrl_i   (f_ctrl),
    .sof_o    (d_sof),
    .eof_o    (d_eof),
    .len_o    (d_len),
    .len_bad_o(d_len_bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_HALT;
      err_q       <= ERR_NONE;
      cur_q       <= '0;
      tail_q      <= '0;
      at_tail_q   <= 1'b0;
      stop_pend_q <= 1'b0;
      act_len_q   <= '0;
    end else if (soft_rst_i) begin
      state_q     <= ST_HALT;
      err_q       <= ERR_NONE;
      at_tail_q   <= 1'b0;
      stop_pend_q <= 1'b0;
    end else begin
      if (tail_we_i && state_q != ST_ERROR) tail_q <= tail_wdata_i;
      unique case (state_q)
        ST_HALT: begin
          if (cur_we_i) begin
            cur_q     <= cur_wdata_i;
            at_tail_q <= 1'b0;
          end else if (tail_we_i && at_tail_q) begin
            cur_q     <= f_next;
            at_tail_q <= 1'b0;
          end
          if (run_i) begin
            stop_pend_q <= 1'b0;
            state_q     <= (at_tail_q && !cur_we_i && !tail_we_i) ? ST_IDLE : ST_LAUNCH;
          end
        end
        ST_LAUNCH: begin
          if (stop_hit) begin
            stop_pend_q <= 1'b0;
            state_q     <= ST_HALT;
          end else if (misaligned) begin
            err_q   <= ERR_ALIGN;
            state_q <= ST_ERROR;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          stop_pend_q <= stop_hit;
          if (f_done) begin
            if (d_len_bad) begin
              err_q   <= ERR_LEN;
              state_q <= ST_ERROR;
            end else begin
              state_q <= ST_DISPATCH;
            end
          end
        end
        ST_DISPATCH: begin
          stop_pend_q <= stop_hit;
          if (mov_ready_i) state_q <= ST_XFER;
        end
        ST_XFER: begin
          stop_pend_q <= stop_hit;
          if (mov_done_i) begin
            if (mov_err_i) begin
              err_q   <= ERR_MOVER;
              state_q <= ST_ERROR;
            end else begin
              act_len_q <= mov_xfer_len_i;
              state_q   <= ST_WBACK;
            end
          end
        end
        ST_WBACK: begin
          stop_pend_q <= stop_hit;
          if (wb_ready_i) begin
            stop_pend_q <= 1'b0;
            if (at_tail_cmp) begin
              at_tail_q <= 1'b1;
              state_q   <= stop_hit ? ST_HALT : ST_IDLE;
            end else begin
              cur_q   <= f_next;
              state_q <= stop_hit ? ST_HALT : ST_LAUNCH;
            end
          end
        end
        ST_IDLE: begin
          if (stop_i) begin
            state_q <= ST_HALT;
          end else if (tail_we_i) begin
            cur_q     <= f_next;
            at_tail_q <= 1'b0;
            state_q   <= ST_LAUNCH;
          end
        end
        ST_ERROR: ;
        default: state_q <= ST_HALT;
      endcase
    end
  end

  assign mov_valid_o = (state_q == ST_DISPATCH);
  assign mov_addr_o  = f_buf;
  assign mov_len_o   = d_len;
  assign mov_sof_o   = d_sof;
  assign mov_eof_o   = d_eof;
  assign wb_valid_o  = (state_q == ST_WBACK);
  assign wb_addr_o   = cur_q + AW'(STAT_OFS);
  assign wb_data_o   = {1'b1, {(DW-1-LEN_W){1'b0}}, act_len_q};
  assign halted_o    = (state_q == ST_HALT) || (state_q == ST_ERROR);
  assign idle_o      = (state_q == ST_IDLE);
  assign err_code_o  = err_q;
  assign cur_desc_o  = cur_q;

  // R5
  idle_at_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (cur_desc_o == tail_q));

  // R12
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q != ERR_NONE && !soft_rst_i) |=> (err_q == $past(err_q)) && halted_o);

  // R9
  no_cmd_in_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_code_o != 2'd0) |-> !mov_valid_o && !rd_req_o && !wb_valid_o);

  // R7
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !rd_req_o && !mov_valid_o && !wb_valid_o);

  // R11
  mover_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XFER && mov_done_i && mov_err_i && !soft_rst_i)
      |=> (err_code_o == 2'd3) && !wb_valid_o);

  // R8
  stop_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WBACK && wb_ready_i && stop_hit && !soft_rst_i) |=> halted_o);

  // R2
  bus_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_req_o, mov_valid_o, wb_valid_o}));
endmodule

// File: tb/sg_chain_walker_test.sv
module sg_chain_walker_test;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          soft_rst = 0, run = 0, stop = 0, cur_we = 0, tail_we = 0;
  logic [AW-1:0] cur_wdata = '0, tail_wdata = '0;
  logic          rd_req, rd_valid = 0;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data = '0;
  logic          mov_valid, mov_ready = 0, mov_sof, mov_eof;
  logic [AW-1:0] mov_addr;
  logic [LW-1:0] mov_len;
  logic          mov_done = 0, mov_err = 0;
  logic [LW-1:0] mov_xfer_len = '0;
  logic          wb_valid, wb_ready = 0;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;
  logic          halted, idle;
  logic [1:0]    err_code;
  logic [AW-1:0] cur_desc;

  sg_chain_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .run_i(run), .stop_i(stop),
    .cur_we_i(cur_we), .cur_wdata_i(cur_wdata), .tail_we_i(tail_we), .tail_wdata_i(tail_wdata),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .mov_valid_o(mov_valid), .mov_ready_i(mov_ready), .mov_addr_o(mov_addr), .mov_len_o(mov_len),
    .mov_sof_o(mov_sof), .mov_eof_o(mov_eof), .mov_done_i(mov_done), .mov_err_i(mov_err),
    .mov_xfer_len_i(mov_xfer_len), .wb_valid_o(wb_valid), .wb_ready_i(wb_ready),
    .wb_addr_o(wb_addr), .wb_data_o(wb_data), .halted_o(halted), .idle_o(idle),
    .err_code_o(err_code), .cur_desc_o(cur_desc)
  );

  localparam logic [31:0] DA = 32'h100, DB = 32'h140, DC = 32'h180, DD = 32'h1C0, DE = 32'h200;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [0:255];
  logic [AW+LW+1:0] exp_cmd_q [$];
  logic [AW+DW-1:0] exp_wb_q [$];
  int n_rd = 0, n_wb = 0, n_cmd = 0;
  bit wb_due = 0, mov_err_arm = 0;
  bit rd_pend = 0;
  int rd_lat = 0;
  logic [AW-1:0] rd_pend_addr = '0;
  bit mv_busy = 0;
  int mv_cnt = 0;
  logic [LW-1:0] mv_len = '0;

  task automatic chk(bit ok, string rq, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] mk_ctrl(bit sof, bit eof, int len);
    return {sof, eof, 14'd0, 16'(len)};
  endfunction

  // reference: descriptor d completes with command from memory and status of len-1
  task automatic expect_desc(logic [31:0] d, bit with_wb);
    logic [31:0] c;
    c = mem[(d >> 2) + 2];
    exp_cmd_q.push_back({mem[(d >> 2) + 1], c[15:0], c[31], c[30]});
    if (with_wb) exp_wb_q.push_back({d + 32'd12, 1'b1, 15'd0, 16'(c[15:0] - 16'd1)});
  endtask

  // environment: memory, mover, writeback sink; compared on every clock
  always @(negedge clk) begin
    rd_valid = 1'b0;
    mov_done = 1'b0;
    mov_err  = 1'b0;
    if (rst_n) begin
      if (rd_pend) begin
        if (rd_lat == 0) begin
          rd_valid = 1'b1;
          rd_data  = mem[rd_pend_addr[9:2]];
          rd_pend  = 0;
        end else rd_lat--;
      end
      if (rd_req) begin
        n_rd++;
        chk(!wb_due, "R3 writeback before next fetch", rd_addr, 0);
        rd_pend = 1; rd_lat = 1; rd_pend_addr = rd_addr;
      end
      if (mv_busy) begin
        if (mv_cnt == 0) begin
          mov_done     = 1'b1;
          mov_xfer_len = mv_len - 16'd1;
          mov_err      = mov_err_arm;
          if (mov_err_arm) wb_due = 0;
          mov_err_arm  = 0;
          mv_busy      = 0;
        end else mv_cnt--;
      end
      mov_ready = ~mov_ready;
      if (mov_valid && mov_ready) begin
        n_cmd++;
        if (exp_cmd_q.size() == 0) chk(0, "R2 unexpected mover command", mov_addr, 0);
        else begin
          logic [AW+LW+1:0] e;
          e = exp_cmd_q.pop_front();
          chk({mov_addr, mov_len, mov_sof, mov_eof} == e, "R2 mover command",
              {mov_addr, mov_len, mov_sof, mov_eof}, e);
        end
        mv_busy = 1; mv_cnt = 3; mv_len = mov_len; wb_due = 1;
      end
      wb_ready = wb_valid;
      if (wb_valid && wb_ready) begin
        n_wb++;
        wb_due = 0;
        mem[wb_addr[9:2]] = wb_data;
        if (exp_wb_q.size() == 0) chk(0, "R3 unexpected writeback", wb_addr, 0);
        else begin
          logic [AW+DW-1:0] w;
          w = exp_wb_q.pop_front();
          chk({wb_addr, wb_data} == w, "R3 status writeback", {wb_addr, wb_data}, w);
        end
      end
    end
  end

  task automatic pulse_run();  @(negedge clk); run = 1;  @(negedge clk); run = 0;  endtask
  task automatic pulse_stop(); @(negedge clk); stop = 1; @(negedge clk); stop = 0; endtask
  task automatic pulse_srst(); @(negedge clk); soft_rst = 1; @(negedge clk); soft_rst = 0; endtask
  task automatic wr_cur(logic [31:0] a);
    @(negedge clk); cur_we = 1; cur_wdata = a; @(negedge clk); cur_we = 0;
  endtask
  task automatic wr_tail(logic [31:0] a);
    @(negedge clk); tail_we = 1; tail_wdata = a; @(negedge clk); tail_we = 0;
  endtask

  task automatic wait_for(bit want_idle, string rq);
    int n;
    n = 0;
    while (!(want_idle ? idle : halted) && n < 2000) begin
      @(negedge clk); n++;
    end
    chk(n < 2000, rq, n, 0);
  endtask

  task automatic queues_empty(string rq);
    chk(exp_cmd_q.size() == 0 && exp_wb_q.size() == 0, rq, exp_cmd_q.size() + exp_wb_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_test();
  end

  initial begin
    int rd0, cmd0, wb0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[(DA>>2)+0] = DB; mem[(DA>>2)+1] = 32'h1000_0000; mem[(DA>>2)+2] = mk_ctrl(1, 0, 64);
    mem[(DB>>2)+0] = DC; mem[(DB>>2)+1] = 32'h2000_0040; mem[(DB>>2)+2] = mk_ctrl(0, 0, 128);
    mem[(DC>>2)+0] = DA; mem[(DC>>2)+1] = 32'h3000_0080; mem[(DC>>2)+2] = mk_ctrl(0, 1, 32);
    mem[(DD>>2)+0] = DA; mem[(DD>>2)+1] = 32'h4000_0000; mem[(DD>>2)+2] = mk_ctrl(1, 0, 6);
    mem[(DE>>2)+0] = DD; mem[(DE>>2)+1] = 32'h5000_0003; mem[(DE>>2)+2] = mk_ctrl(1, 1, 7);

    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(halted == 1 && idle == 0, "R1 halted after reset", {halted, idle}, 2'b10);
    chk(err_code == 0, "R1 no error after reset", err_code, 0);
    repeat (10) @(negedge clk);
    chk(n_rd == 0, "R1 no reads before run", n_rd, 0);

    // R7 register writes while halted do not start work
    wr_cur(DA);
    wr_tail(DC);
    repeat (20) @(negedge clk);
    chk(n_rd == 0, "R7 no fetch while halted", n_rd, 0);
    chk(cur_desc == DA, "R7 current register written", cur_desc, DA);

    // R4 R5 walk A,B,C and park at tail
    expect_desc(DA, 1); expect_desc(DB, 1); expect_desc(DC, 1);
    pulse_run();
    wait_for(1, "R5 reach idle at tail");
    queues_empty("R4 all descriptors walked");
    chk(halted == 0, "R5 still running when idle", halted, 0);
    chk(cur_desc == DC, "R5 parked on tail", cur_desc, DC);
    chk(n_rd == 9, "R2 three reads per descriptor", n_rd, 9);
    chk(mem[(DC>>2)+3] == {1'b1, 15'd0, 16'd31}, "R3 status word in memory", mem[(DC>>2)+3], {1'b1, 15'd0, 16'd31});
    repeat (20) @(negedge clk);
    chk(n_rd == 9, "R5 no reads while idle", n_rd, 9);

    // R6 move tail while idle: restart at C.next (wrap to A)
    expect_desc(DA, 1); expect_desc(DB, 1);
    wr_tail(DB);
    wait_for(1, "R6 idle after restart");
    queues_empty("R6 restarted walk wraps");
    chk(cur_desc == DB, "R6 parked on new tail", cur_desc, DB);

    // R8 stop during a walk
    expect_desc(DC, 1);
    wr_tail(DA);
    pulse_stop();
    wait_for(0, "R8 halt after stop");
    queues_empty("R8 in-flight descriptor finished");
    chk(cur_desc == DA, "R8 current advanced to next", cur_desc, DA);
    cmd0 = n_cmd;
    repeat (30) @(negedge clk);
    chk(n_cmd == cmd0, "R8 no commands while paused", n_cmd, cmd0);
    expect_desc(DA, 1);
    pulse_run();
    wait_for(1, "R8 resume to idle");
    queues_empty("R8 resumed at next");
    chk(cur_desc == DA, "R8 parked after resume", cur_desc, DA);

    // R9 whole-packet descriptor exempt, split-packet odd length faults
    pulse_stop();
    wr_cur(DE);
    wr_tail(DD);
    expect_desc(DE, 1);
    pulse_run();
    wait_for(0, "R9 halt on length error");
    queues_empty("R9 exempt descriptor done, no command for bad one");
    chk(err_code == 2, "R9 length error code", err_code, 2);
    chk(cur_desc == DD, "R9 current on faulting descriptor", cur_desc, DD);
    rd0 = n_rd;
    pulse_run();
    repeat (20) @(negedge clk);
    chk(err_code == 2 && halted == 1, "R12 run ignored in error", {err_code, halted}, 3'b101);
    chk(n_rd == rd0, "R12 no reads in error", n_rd, rd0);
    pulse_srst();
    chk(err_code == 0 && halted == 1, "R12 soft reset clears error", {err_code, halted}, 3'b001);
    chk(idle == 0, "R1 not idle after soft reset", idle, 0);

    // R10 misaligned descriptor address
    wr_cur(32'h104);
    rd0 = n_rd;
    pulse_run();
    repeat (10) @(negedge clk);
    chk(err_code == 1, "R10 alignment error code", err_code, 1);
    chk(n_rd == rd0, "R10 no read issued", n_rd, rd0);
    pulse_srst();

    // R11 mover fault
    wr_cur(DA);
    wr_tail(DA);
    mov_err_arm = 1;
    expect_desc(DA, 0);
    wb0 = n_wb;
    pulse_run();
    wait_for(0, "R11 halt on mover fault");
    chk(err_code == 3, "R11 mover error code", err_code, 3);
    chk(n_wb == wb0, "R11 no writeback", n_wb, wb0);
    queues_empty("R11 command issued");
    pulse_srst();
    chk(err_code == 0 && halted == 1, "R1 soft reset after mover fault", {err_code, halted}, 3'b001);

    repeat (5) @(negedge clk);
    finish_test();
  end
endmodule